// File: doc/BRIEF.md
# Interrupt Routing Autodetect Classifier

This block watches configuration-space writes on their way to the bus. It decides whether the software expects an old, wrong interrupt routing. It looks only at writes to the per-device interrupt-line register. The written value is compared against the patterns that known faulty software produces for the device's slot. The first write that tells one case from the other sets the mode, and the mode then stays fixed until reset.

The result is a two-bit mode code that an interrupt router downstream uses to pick its routing. The write itself passes through the block unchanged on the same cycle. A reset-time input selects the starting mode, so a system that already knows its software can skip detection. A variant input turns detection off for the board variant that never had the fault.

Top module: `irq_route_detect`

## Requirements
- R1: While reset is asserted, `mode` follows `init_mode`: 2'b00 loads assume-ok, 2'b01 loads broken, 2'b10 loads force-ok, and 2'b11 loads assume-ok. `mode` never shows 2'b11.
- R2: A write is classified only if all of these hold: `cfg_wr` is high, `variant_alt` is low, `cfg_addr[7:0]` equals 8'h3C, and `mode` is assume-ok. Any other cycle leaves `mode` unchanged.
- R3: The slot number is `cfg_addr[15:11]`, and only its low two bits (slot mod 4 = `cfg_addr[12:11]`) take part in the decision. Only `cfg_wdata[7:0]` is compared, so the upper data bits have no effect.
- R4: A written byte of 27 leaves the mode at assume-ok when slot mod 4 is 2. For any other slot it sets broken.
- R5: A written byte equal to 27 + (slot mod 4), or to 91 + (slot mod 4), sets broken.
- R6: Any other written byte sets force-ok.
- R7: Once `mode` is broken or force-ok, it keeps that value until the next reset, whatever is written.
- R8: `fwd_wr`, `fwd_addr` and `fwd_wdata` equal `cfg_wr`, `cfg_addr` and `cfg_wdata` in the same cycle, whatever the classification.
- R9: `mode` is registered. A classified write sampled at a rising clock edge shows its result on `mode` just after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_mode | input | 2 | Mode loaded while reset is held |
| variant_alt | input | 1 | High selects the board variant that has no detection |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration address; bits [15:8] hold the device/function number |
| cfg_wdata | input | DATA_W | Configuration write data |
| fwd_wr | output | 1 | Forwarded write strobe |
| fwd_addr | output | ADDR_W | Forwarded address |
| fwd_wdata | output | DATA_W | Forwarded write data |
| mode | output | 2 | 00 assume-ok, 01 broken, 10 force-ok |

## Verification
The forwarded write signals are combinational, so they are checked 1 ns after the inputs are driven, in the same cycle. The mode result passes through one register. The driver applies each write at a falling edge and queues the expected mode. The monitor pops the queue 5 ns after the next rising edge, which is the first point where that write's result can be seen. The reset-time mode is checked while reset is still held, because the register loads `init_mode` asynchronously.

// File: rtl/irq_route_detect.sv
module irq_route_detect #(
  parameter int          ADDR_W    = 24,
  parameter int          DATA_W    = 32,
  parameter logic [7:0]  LINE_OFS  = 8'h3C,
  parameter logic [7:0]  BASE_LINE = 8'd27,
  parameter logic [7:0]  SHIFT_OFS = 8'd64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        init_mode,
  input  logic              variant_alt,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              fwd_wr,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [DATA_W-1:0] fwd_wdata,
  output logic [1:0]        mode
);
  localparam logic [1:0] M_ASSUME = 2'b00;
  localparam logic [1:0] M_BROKEN = 2'b01;
  localparam logic [1:0] M_FORCE  = 2'b10;
  localparam logic [1:0] SLOT_SAFE = 2'd2;

  logic [1:0] mode_q, verdict, init_dec;
  logic [1:0] slot4;
  logic [7:0] line_val, pat_low, pat_high;
  logic       take;

  assign fwd_wr    = cfg_wr;
  assign fwd_addr  = cfg_addr;
  assign fwd_wdata = cfg_wdata;

  assign slot4    = cfg_addr[12:11];
  assign line_val = cfg_wdata[7:0];
  assign pat_low  = BASE_LINE + {6'd0, slot4};
  assign pat_high = BASE_LINE + SHIFT_OFS + {6'd0, slot4};

  assign init_dec = (init_mode == 2'b11) ? M_ASSUME : init_mode;

  always_comb begin
    if (line_val == BASE_LINE)
      verdict = (slot4 == SLOT_SAFE) ? M_ASSUME : M_BROKEN;
    else if (line_val == pat_low || line_val == pat_high)
      verdict = M_BROKEN;
    else
      verdict = M_FORCE;
  end

  assign take = cfg_wr && !variant_alt && (cfg_addr[7:0] == LINE_OFS) && (mode_q == M_ASSUME);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    mode_q <= init_dec;
    else if (take) mode_q <= verdict;

  assign mode = mode_q;
endmodule

module irq_route_detect_chk #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              variant_alt,
  input logic              cfg_wr,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [DATA_W-1:0] cfg_wdata,
  input logic [1:0]        mode
);
  a_r1_legal_code: assert property (@(posedge clk) disable iff (!rst_n) mode != 2'b11);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b00) |=> $stable(mode));

  a_r2_alt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    variant_alt |=> $stable(mode));

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(mode));

  a_r2_offset_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_addr[7:0] != 8'h3C) |=> $stable(mode));

  a_r5_shifted_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && cfg_wr && !variant_alt && cfg_addr[7:0] == 8'h3C &&
     cfg_wdata[7:0] == 8'd91 + {6'd0, cfg_addr[12:11]}) |=> (mode == 2'b01));
endmodule

bind irq_route_detect irq_route_detect_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .variant_alt(variant_alt), .cfg_wr(cfg_wr),
  .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .mode(mode)
);

// File: tb/tb_irq_route_detect.sv
module tb_irq_route_detect;
  localparam int AW = 24;
  localparam int DW = 32;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [1:0]    init_mode = 0;
  logic          variant_alt = 0;
  logic          cfg_wr = 0;
  logic [AW-1:0] cfg_addr = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic          fwd_wr;
  logic [AW-1:0] fwd_addr;
  logic [DW-1:0] fwd_wdata;
  logic [1:0]    mode;

  int checks = 0, errors = 0;
  logic [1:0] model = 0;
  bit done = 0;

  typedef struct { logic [1:0] m; string tag; } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  irq_route_detect dut (
    .clk(clk), .rst_n(rst_n), .init_mode(init_mode), .variant_alt(variant_alt),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .fwd_wr(fwd_wr), .fwd_addr(fwd_addr), .fwd_wdata(fwd_wdata), .mode(mode)
  );

  task automatic check2(string tag, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s mode act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] classify(logic [1:0] cur, logic alt, logic wr,
                                          logic [AW-1:0] a, logic [DW-1:0] d);
    int s, v;
    s = int'(a[15:11]) % 4;
    v = int'(d[7:0]);
    if (cur != 0 || alt || !wr || a[7:0] != 8'h3C) return cur;
    if (v == 27) return (s == 2) ? 2'd0 : 2'd1;
    if (v == 27 + s || v == 91 + s) return 2'd1;
    return 2'd2;
  endfunction

  task automatic do_reset(logic [1:0] im, logic [1:0] exp);
    @(negedge clk);
    rst_n = 0; init_mode = im; cfg_wr = 0;
    @(negedge clk);
    check2("R1", mode, exp);
    rst_n = 1;
    model = exp;
  endtask

  task automatic drive(string tag, logic wr, logic alt, int slot, logic [7:0] ofs, logic [DW-1:0] d);
    exp_t e;
    @(negedge clk);
    cfg_wr = wr; variant_alt = alt;
    cfg_addr = AW'((slot & 31) << 11) | AW'(ofs);
    cfg_wdata = d;
    model = classify(model, alt, wr, cfg_addr, d);
    e.m = model; e.tag = tag;
    q.push_back(e);
    #1;
    checks++;
    if (fwd_wr !== wr || fwd_addr !== cfg_addr || fwd_wdata !== d) begin
      errors++;
      $display("FAIL R8 fwd act=%0b/%h/%h exp=%0b/%h/%h", fwd_wr, fwd_addr, fwd_wdata, wr, cfg_addr, d);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check2(e.tag, mode, e.m);
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset codes
    do_reset(2'b01, 2'b01);
    do_reset(2'b10, 2'b10);
    do_reset(2'b11, 2'b00);
    do_reset(2'b00, 2'b00);
    // R4: 27 in slot mod 4 == 2 stays assume-ok; R9 timing via scoreboard
    drive("R4", 1, 0, 2, 8'h3C, 32'd27);
    drive("R4", 1, 0, 6, 8'h3C, 32'd27);
    // R5 low pattern for slot 2 (29) -> broken
    drive("R5", 1, 0, 2, 8'h3C, 32'd29);
    // R7 sticky broken
    drive("R7", 1, 0, 0, 8'h3C, 32'd200);
    drive("R7", 1, 0, 1, 8'h3C, 32'd28);

    do_reset(2'b00, 2'b00);
    // R2 gating cases
    drive("R2", 1, 0, 0, 8'h40, 32'd77);
    drive("R2", 0, 0, 0, 8'h3C, 32'd77);
    drive("R2", 1, 1, 0, 8'h3C, 32'd77);
    drive("R2", 1, 1, 0, 8'h3C, 32'd27);
    // R5 shifted pattern, slot 5 (mod 4 = 1): 92
    drive("R5", 1, 0, 5, 8'h3C, 32'd92);

    do_reset(2'b00, 2'b00);
    // R4: 27 in slot 3 -> broken
    drive("R4", 1, 0, 3, 8'h3C, 32'd27);

    do_reset(2'b00, 2'b00);
    // R6 other value -> force-ok, then R7 sticky
    drive("R6", 1, 0, 0, 8'h3C, 32'd200);
    drive("R7", 1, 0, 1, 8'h3C, 32'd27);
    drive("R7", 1, 0, 1, 8'h3C, 32'd92);

    do_reset(2'b00, 2'b00);
    // R3 only low byte: 0x15C -> byte 92, slot 1 -> broken
    drive("R3", 1, 0, 1, 8'h3C, 32'h0000_015C);

    do_reset(2'b00, 2'b00);
    // R3 slot taken from addr[15:11]: slot 30 (mod 4 = 2) byte 93 -> broken
    drive("R3", 1, 0, 30, 8'h3C, 32'hFF00_005D);

    do_reset(2'b00, 2'b00);
    // R6: 91 in slot 3 is not a pattern (94 would be) -> force-ok
    drive("R6", 1, 0, 3, 8'h3C, 32'd91);

    do_reset(2'b00, 2'b00);
    // R5: 30 in slot 3 -> broken; upper bits set
    drive("R5", 1, 0, 7, 8'h3C, 32'hABCD_001E);

    @(negedge clk);
    cfg_wr = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule